// File: doc/BRIEF.md
# Indirect Peripheral Clock Gate Controller

This block turns one master clock into a set of per-peripheral clock-enable strobes. Each peripheral can be switched on or off and can run at the master rate divided by 1, 2, 4 or 8. All of that state is reached through one 32-bit command register. A write names a peripheral ID. With its command flag set, the write also stores a new enable bit and divider code for that ID. With the flag clear, the write only chooses which peripheral a later read reports. A read returns the chosen peripheral's enable bit and divider code one cycle after the read strobe.

IDs 0 and 1 are wired on and undivided. A parameter mask marks which of the other IDs have a divider. Each output is a one-cycle strobe at the divided rate, meant to drive a clock-enable or a glitch-free gate downstream. A new divider code waits for the end of the current divided period before it applies, so a period is never cut short.

Top module: `periph_clk_gate`

## Requirements
- R1: After reset, every ID from 2 upward is disabled with divider code 0, and the selected ID is 0. IDs 0 and 1 strobe on every cycle from the first cycle after reset.
- R2: The command word has the ID at bits 5:0, the command flag at bit 12, the divider code at bits 17:16 and the enable flag at bit 28. All other bits are ignored on write.
- R3: A write with the command flag at 1 and an in-range ID of 2 or more stores the enable bit and code for that ID. When the enable bit is 0, that ID's strobe is low from the cycle after the write edge.
- R4: A write with the command flag at 0 changes no enable bit and no code, and only selects the ID. A read strobe gives rvalid_o high in the next cycle. In that cycle rdata_o holds the selected ID's enable at bit 28, its code at bits 17:16 and the selected ID at bits 5:0, with every other bit 0.
- R5: An enabled ID with active code c strobes once every 2^c cycles. After the enabling write edge, its first strobe falls in the 2^c-th cycle.
- R6: A code written while an ID is enabled takes effect only after the current divided period has finished. Until then the old period runs in full.
- R7: Command writes to IDs 0 and 1 have no effect. These IDs keep strobing every cycle and read back with enable 1 and code 0.
- R8: An ID without a divider (default: IDs 8 to 15) strobes every cycle while enabled, whatever code is written, and reads back code 0.
- R9: A write whose ID is NUM_IDS or more (default 48) is ignored entirely. It changes neither the state nor the selected ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write strobe for the command register |
| rd_valid_i | input | 1 | Read strobe for the command register |
| wdata_i | input | 32 | Write data (command word) |
| rdata_o | output | 32 | Readback of the selected ID |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_valid_i |
| clk_en_o | output | NUM_IDS | Per-ID divided clock-enable strobes |

## Verification
The assertions assume that a read and a write never arrive in the same cycle. They also assume that the bus holds wdata_i stable only while a strobe is high, with no meaning at other times. The bench keeps to both rules: every stimulus step drives at most one strobe and clears both strobes between accesses. The behavioural model is compared against every output on every cycle. It covers divider changes landing mid-period, select-only writes that carry a stray enable bit of 0, and commands addressed to wired-on, divider-less and out-of-range IDs.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int DATA_W  = 32;
  localparam int ID_W    = 6;
  localparam int CODE_W  = 2;
  localparam int MAX_IDS = 1 << ID_W;
  localparam int CNT_W   = (1 << CODE_W) - 1;
  // field positions of the command word
  localparam int CMD_BIT  = 12;
  localparam int CODE_LSB = 16;
  localparam int EN_BIT   = 28;

  typedef logic [ID_W-1:0]   id_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/pcg_regif.sv
module pcg_regif
  import pcg_pkg::*;
#(
  parameter int NUM_IDS = 48
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_valid_i,
  input  logic                      rd_valid_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [NUM_IDS-1:0]        en_vec_i,
  input  code_t [NUM_IDS-1:0]       code_vec_i,
  output logic                      upd_o,
  output id_t                       upd_id_o,
  output logic                      upd_en_o,
  output code_t                     upd_code_o,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      rvalid_o
);
  localparam logic [ID_W:0] NUM_L = (ID_W+1)'(NUM_IDS);

  id_t   wr_id, sel_q;
  logic  id_ok;
  logic [DATA_W-1:0] rd_word;
  logic  unused_bits;

  assign wr_id      = wdata_i[ID_W-1:0];
  assign id_ok      = {1'b0, wr_id} < NUM_L;
  assign upd_o      = wr_valid_i & id_ok & wdata_i[CMD_BIT];
  assign upd_id_o   = wr_id;
  assign upd_en_o   = wdata_i[EN_BIT];
  assign upd_code_o = wdata_i[CODE_LSB +: CODE_W];
  assign unused_bits = ^{wdata_i[31:29], wdata_i[27:18], wdata_i[15:13], wdata_i[11:6]};

  always_comb begin
    rd_word = '0;
    rd_word[EN_BIT]                = en_vec_i[sel_q];
    rd_word[CODE_LSB +: CODE_W]    = code_vec_i[sel_q];
    rd_word[ID_W-1:0]              = sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      if (wr_valid_i && id_ok) sel_q <= wr_id;
      rvalid_o <= rd_valid_i;
      if (rd_valid_i) rdata_o <= rd_word;
    end
  end

  assert_sel_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, sel_q} < NUM_L);
  assert_read_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rvalid_o);
  assert_bad_id_keeps_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !id_ok) |=> $stable(sel_q));
endmodule

// File: rtl/pcg_slot.sv
module pcg_slot
  import pcg_pkg::*;
#(
  parameter bit ALWAYS_ON = 1'b0,
  parameter bit HAS_DIV   = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hit_i,
  input  logic  wr_en_i,
  input  code_t wr_code_i,
  output logic  en_o,
  output code_t code_o,
  output logic  strobe_o
);
  localparam bit DIV_OK = HAS_DIV && !ALWAYS_ON;

  logic             en_q, en_nx;
  code_t            pend_q, pend_nx, act_q;
  logic [CNT_W-1:0] cnt_q, mask;
  logic             boundary;

  assign en_nx    = hit_i ? (ALWAYS_ON ? 1'b1 : wr_en_i) : en_q;
  assign pend_nx  = hit_i ? (DIV_OK ? wr_code_i : code_t'(0)) : pend_q;
  assign mask     = ~({CNT_W{1'b1}} << act_q);
  assign boundary = (cnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= ALWAYS_ON;
      pend_q <= '0;
      act_q  <= '0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_nx;
      pend_q <= pend_nx;
      // new code is adopted only while idle or at a period boundary
      if (!en_q || boundary) begin
        cnt_q <= '0;
        act_q <= pend_nx;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign en_o     = en_q;
  assign code_o   = pend_q;
  assign strobe_o = en_q & boundary;

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= mask);
  assert_div_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !boundary) |=> $stable(act_q));
endmodule

// File: rtl/periph_clk_gate.sv
module periph_clk_gate
  import pcg_pkg::*;
#(
  parameter int                   NUM_IDS     = 48,
  parameter int                   ALWAYS_ON_N = 2,
  parameter logic [MAX_IDS-1:0]   DIV_CAP     = 64'hFFFF_FFFF_FFFF_00FF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic               rd_valid_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               rvalid_o,
  output logic [NUM_IDS-1:0] clk_en_o
);
  logic                 upd, upd_en;
  id_t                  upd_id;
  code_t                upd_code;
  logic [NUM_IDS-1:0]   en_vec;
  code_t [NUM_IDS-1:0]  code_vec;

  pcg_regif #(.NUM_IDS(NUM_IDS)) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .rd_valid_i (rd_valid_i),
    .wdata_i    (wdata_i),
    .en_vec_i   (en_vec),
    .code_vec_i (code_vec),
    .upd_o      (upd),
    .upd_id_o   (upd_id),
    .upd_en_o   (upd_en),
    .upd_code_o (upd_code),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_slot
    pcg_slot #(
      .ALWAYS_ON (i < ALWAYS_ON_N),
      .HAS_DIV   (DIV_CAP[i])
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (upd && (upd_id == id_t'(i))),
      .wr_en_i   (upd_en),
      .wr_code_i (upd_code),
      .en_o      (en_vec[i]),
      .code_o    (code_vec[i]),
      .strobe_o  (clk_en_o[i])
    );
  end

  assert_select_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wdata_i[CMD_BIT]) |=> ($stable(en_vec) && $stable(code_vec)));
  assert_cmd_disable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wdata_i[CMD_BIT] && !wdata_i[EN_BIT] &&
     wdata_i[ID_W-1:0] >= id_t'(ALWAYS_ON_N) && int'(wdata_i[ID_W-1:0]) < NUM_IDS)
    |=> !clk_en_o[$past(wdata_i[ID_W-1:0])]);
  assert_wired_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &en_vec[ALWAYS_ON_N-1:0]);
endmodule

// File: tb/sim_periph_clk_gate.sv
module sim_periph_clk_gate;
  localparam int NUM = 48;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_valid_i = 1'b0;
  logic            rd_valid_i = 1'b0;
  logic [31:0]     wdata_i = '0;
  logic [31:0]     rdata_o;
  logic            rvalid_o;
  logic [NUM-1:0]  clk_en_o;

  periph_clk_gate u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .rd_valid_i(rd_valid_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .clk_en_o(clk_en_o)
  );

  always #4 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";

  int m_en[NUM];
  int m_pend[NUM];
  int m_act[NUM];
  int m_cnt[NUM];
  int m_sel = 0;
  logic        exp_rv = 1'b0;
  logic [31:0] exp_rd = '0;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit has_div(int i);
    return !(i >= 8 && i < 16);
  endfunction

  function automatic logic [31:0] cmd(int id, bit c, bit en, int code);
    logic [31:0] w = '0;
    w[5:0] = 6'(id); w[12] = c; w[28] = en; w[17:16] = 2'(code);
    return w;
  endfunction

  function automatic logic [31:0] readback(int id);
    logic [31:0] w = '0;
    w[5:0] = 6'(id);
    if (id < 2) w[28] = 1'b1;
    else begin w[28] = 1'(m_en[id]); w[17:16] = 2'(m_pend[id]); end
    return w;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [NUM-1:0] e;
    for (int i = 0; i < NUM; i++)
      e[i] = (m_en[i] != 0) && (m_cnt[i] == (1 << m_act[i]) - 1);
    check(cur_req, 64'(clk_en_o), 64'(e), "strobes");
    check(cur_req, 64'(rvalid_o), 64'(exp_rv), "rvalid");
    if (exp_rv) check(cur_req, 64'(rdata_o), 64'(exp_rd), "rdata");
  endtask

  task automatic model(bit wr, bit rd, logic [31:0] d);
    int id = int'(d[5:0]);
    bit hit = wr && d[12] && id < NUM;
    for (int i = 0; i < NUM; i++) begin
      int pn = m_pend[i];
      int en_n = m_en[i];
      if (hit && id == i && i >= 2) begin
        en_n = int'(d[28]);
        pn = has_div(i) ? int'(d[17:16]) : 0;
      end
      if (m_en[i] == 0 || m_cnt[i] == (1 << m_act[i]) - 1) begin
        m_cnt[i] = 0; m_act[i] = pn;
      end else m_cnt[i]++;
      m_en[i] = en_n; m_pend[i] = pn;
    end
    exp_rv = rd;
    if (rd) exp_rd = readback(m_sel);
    if (wr && id < NUM) m_sel = id;
  endtask

  task automatic step(bit wr, bit rd, logic [31:0] d);
    @(negedge clk_i);
    compare();
    wr_valid_i = wr; rd_valid_i = rd; wdata_i = wr ? d : '0;
    model(wr, rd, d);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0);
  endtask

  task automatic rd_sel(int id);
    step(1'b1, 1'b0, cmd(id, 1'b0, 1'b0, 0));
    step(1'b0, 1'b1, '0);
    idle(2);
  endtask

  initial begin
    for (int i = 0; i < NUM; i++) begin
      m_en[i] = (i < 2) ? 1 : 0; m_pend[i] = 0; m_act[i] = 0; m_cnt[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state, then read of default selection (ID 0)
    cur_req = "R1";
    idle(3);
    step(1'b0, 1'b1, '0);
    idle(2);
    // R2 field layout exercised through command words; R5 divided rates
    cur_req = "R5";
    step(1'b1, 1'b0, cmd(3, 1'b1, 1'b1, 2) | 32'hE7EC_0FC0 & 32'hE00C_0FC0);
    idle(12);
    step(1'b1, 1'b0, cmd(4, 1'b1, 1'b1, 0));
    idle(3);
    step(1'b1, 1'b0, cmd(5, 1'b1, 1'b1, 3));
    idle(20);
    cur_req = "R2";
    rd_sel(3);
    // R6 mid-period code changes
    cur_req = "R6";
    idle(2);
    step(1'b1, 1'b0, cmd(3, 1'b1, 1'b1, 1));
    idle(10);
    step(1'b1, 1'b0, cmd(5, 1'b1, 1'b1, 0));
    idle(4);
    step(1'b1, 1'b0, cmd(3, 1'b1, 1'b1, 3));
    idle(20);
    // R4 select-only writes carrying enable 0 must not disable
    cur_req = "R4";
    rd_sel(4);
    rd_sel(3);
    idle(6);
    // R3 disable by command
    cur_req = "R3";
    step(1'b1, 1'b0, cmd(5, 1'b1, 1'b0, 2));
    idle(4);
    rd_sel(5);
    step(1'b1, 1'b0, cmd(3, 1'b1, 1'b0, 0));
    idle(3);
    // R7 wired-on IDs
    cur_req = "R7";
    step(1'b1, 1'b0, cmd(1, 1'b1, 1'b0, 3));
    idle(3);
    step(1'b1, 1'b0, cmd(0, 1'b1, 1'b0, 2));
    idle(3);
    rd_sel(1);
    // R8 divider-less IDs
    cur_req = "R8";
    step(1'b1, 1'b0, cmd(9, 1'b1, 1'b1, 3));
    idle(6);
    rd_sel(9);
    step(1'b1, 1'b0, cmd(15, 1'b1, 1'b1, 2));
    idle(4);
    // R9 out-of-range IDs
    cur_req = "R9";
    rd_sel(4);
    step(1'b1, 1'b0, cmd(50, 1'b1, 1'b1, 1));
    step(1'b1, 1'b0, cmd(63, 1'b0, 1'b0, 0));
    step(1'b0, 1'b1, '0);
    idle(4);
    @(negedge clk_i);
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule